// File: doc/BRIEF.md
# Pipelined Burst SRAM Command Engine

This block is a clock-accurate model of a synchronous pipelined SRAM whose read and write data share one time slot, so the data bus never needs an idle turnaround cycle between reads and writes. It holds a small word array split into byte lanes. On every rising clock edge it decodes the control inputs and does one of these: it loads a new burst from the external address, continues the running burst through a 2-bit counter, deselects, ignores the edge (clock-enable stall) or drops into sleep.

A read accepted on one enabled edge puts its word on the output register at that edge, which gives a pipelined latency of one. A write accepted on one enabled edge takes its data from the bus at the next enabled edge. Writes with no byte lane enabled and reads with the output enable inactive still use a slot but move no data. Output drive is modelled as a data vector plus an enable. The data vector reads as zero whenever the enable is low.

Top module: `nbt_sram`

## Requirements
- R1: After reset the output enable `dout_en` is low, `dout` is zero, the burst counter is zero and the device is deselected, so a continue command (`adv`=1) issued straight after reset drives nothing.
- R2: With `sleep`=0 and `cke_n`=0, a load (`adv`=0) with `ce_n`=0, `we_n`=1 and `oe_n`=0 at edge k sets `dout_en` high with the word at `addr` on `dout` right after edge k.
- R3: A load with `ce_n`=0 and `we_n`=0 starts a write burst. The data on `din` at the next enabled edge is written into every lane i whose `be_n[i]` was 0 in the command cycle. Lane i is bits [9i+8:9i]. `dout_en` stays low during write bursts whatever `oe_n` is.
- R4: A continue (`adv`=1) after a started burst keeps the burst's direction and ignores `ce_n` and `we_n`. Its word address has the upper bits of the load address, and its low two bits are (load low bits + count) mod 4, with the count going 1, 2, 3, 0, …
- R5: A write command whose `be_n` bits are all 1 writes nothing, and `dout_en` stays low.
- R6: A read command with `oe_n`=1 leaves `dout_en` low, and its continue cycles still advance the burst counter.
- R7: A load with `ce_n`=1 deselects the device. A continue that follows a deselect leaves it deselected, with no write and no drive.
- R8: With `cke_n`=1 (and `sleep`=0) an edge is ignored: `dout`, `dout_en`, the burst counter and any pending write hold. A pending write takes its data at the next enabled edge.
- R9: `sleep`=1 overrides every other input. After that edge `dout_en` is low, a pending write is dropped and the device is deselected.
- R10: `dout` is all zeros whenever `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, low selects on a load |
| sleep | input | 1 | Sleep request, high overrides all |
| adv | input | 1 | High continues the burst, low loads a new command |
| we_n | input | 1 | Low selects a write on a load |
| be_n | input | LANES (2) | Per-lane write enables, active low |
| oe_n | input | 1 | Read output enable, active low |
| cke_n | input | 1 | Clock enable, high stalls the edge |
| addr | input | ADDR_W (8) | External word address |
| din | input | LANES*LANE_W (18) | Write data |
| dout | output | LANES*LANE_W (18) | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |

## Verification
The bound checker watches these rules on every clock: the output enable rises one edge after an enabled read load with the output enable active, stays low after reset, deselect, sleep, write loads and dummy read loads, and stays frozen together with the data across a stalled edge. The bench's scenarios are needed for what lives in the array and the counter: lane-masked writes, wrapping burst order, aborts that leave old data intact, and a counter that keeps stepping through dummy reads. They also cover a write whose data phase crosses a stall, a write dropped by sleep, and the deselect-continue case.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/nbt_lane_ram.sv
module nbt_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read-first, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nbt_burst_addr.sv
module nbt_burst_addr #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [BURST_W-1:0] cnt;
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] lo_nxt;

  always_comb begin
    lo_nxt   = base[BURST_W-1:0] + cnt + BURST_W'(1);
    cur_addr = load ? ext_addr : {base[ADDR_W-1:BURST_W], lo_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      base <= '0;
    end else if (en) begin
      if (load) begin
        cnt  <= '0;
        base <= ext_addr;
      end else if (step) begin
        cnt <= cnt + BURST_W'(1);
      end
    end
  end
endmodule

// File: rtl/nbt_ctrl.sv
module nbt_ctrl
  import nbt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              sleep,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  be_n,
  input  logic              oe_n,
  input  logic              cke_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic [LANES-1:0]  ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic              dout_en
);
  logic              en;
  logic              desel;
  logic              begin_burst;
  logic              step;
  logic              active;
  logic              cur_wr;
  logic              rd_go;
  logic              wr_go;
  op_kind_e          burst_op;
  logic              wr_pend;
  logic [LANES-1:0]  wr_be;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] cur_addr;

  always_comb begin
    en          = ~cke_n & ~sleep;
    begin_burst = ~adv & ~ce_n;
    step        = adv & ~desel;
    active      = begin_burst | step;
    cur_wr      = adv ? (burst_op == OP_WRITE) : ~we_n;
    rd_go       = active & ~cur_wr;
    wr_go       = active & cur_wr & ~(&be_n);
  end

  nbt_burst_addr #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W)
  ) u_baddr (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (begin_burst),
    .step    (step),
    .ext_addr(addr),
    .cur_addr(cur_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      desel    <= 1'b1;
      burst_op <= OP_READ;
      dout_en  <= 1'b0;
      wr_pend  <= 1'b0;
      wr_be    <= '0;
      wr_addr  <= '0;
    end else if (sleep) begin
      desel   <= 1'b1;
      dout_en <= 1'b0;
      wr_pend <= 1'b0;
    end else if (!cke_n) begin
      if (!adv) desel <= ce_n;
      if (begin_burst) burst_op <= we_n ? OP_READ : OP_WRITE;
      dout_en <= rd_go & ~oe_n;
      wr_pend <= wr_go;
      wr_be   <= ~be_n;
      wr_addr <= cur_addr;
    end
  end

  always_comb begin
    ram_re    = en;
    ram_raddr = cur_addr;
    ram_we    = {LANES{en & wr_pend}} & wr_be;
    ram_waddr = wr_addr;
  end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce_n,
  input  logic                    sleep,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [LANES-1:0]        be_n,
  input  logic                    oe_n,
  input  logic                    cke_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;

  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [LANES-1:0]  ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] rd_word;

  nbt_ctrl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BURST_W(BURST_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .sleep    (sleep),
    .adv      (adv),
    .we_n     (we_n),
    .be_n     (be_n),
    .oe_n     (oe_n),
    .cke_n    (cke_n),
    .addr     (addr),
    .ram_re   (ram_re),
    .ram_raddr(ram_raddr),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr),
    .dout_en  (dout_en)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nbt_lane_ram #(
      .ADDR_W(ADDR_W),
      .DATA_W(LANE_W)
    ) u_lane (
      .clk  (clk),
      .we   (ram_we[g]),
      .waddr(ram_waddr),
      .wdata(din[g*LANE_W +: LANE_W]),
      .re   (ram_re),
      .raddr(ram_raddr),
      .rdata(rd_word[g*LANE_W +: LANE_W])
    );
  end

  assign dout = dout_en ? rd_word : '0;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              sleep,
  input logic              adv,
  input logic              we_n,
  input logic              oe_n,
  input logic              cke_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic live;
  assign live = ~cke_n & ~sleep;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !dout_en);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
    live && !adv && !ce_n && we_n && !oe_n |=> dout_en);

  assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
    live && !adv && !ce_n && !we_n |=> !dout_en);

  assert_dummy_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    live && !adv && !ce_n && we_n && oe_n |=> !dout_en);

  assert_deselect_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
    live && !adv && ce_n |=> !dout_en);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cke_n && !sleep |=> $stable(dout_en) && $stable(dout));

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !dout_en);
endmodule

bind nbt_sram nbt_sram_chk #(
  .DATA_W(LANES * LANE_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ce_n   (ce_n),
  .sleep  (sleep),
  .adv    (adv),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .cke_n  (cke_n),
  .dout   (dout),
  .dout_en(dout_en)
);

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;
  localparam int AW = 8;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, sleep = 1'b0, adv = 1'b0, we_n = 1'b1;
  logic [1:0]    be_n = 2'b11;
  logic          oe_n = 1'b1, cke_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  nbt_sram u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .sleep(sleep), .adv(adv),
    .we_n(we_n), .be_n(be_n), .oe_n(oe_n), .cke_n(cke_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  typedef struct packed {
    logic          ce_n;
    logic          slp;
    logic          adv;
    logic          we_n;
    logic [1:0]    be_n;
    logic          oe_n;
    logic          cke_n;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          xen;
    logic [DW-1:0] xd;
    logic [3:0]    req;
  } vec_t;

  localparam logic [DW-1:0] A1 = 18'h2A5C3;
  localparam logic [DW-1:0] A2 = 18'h15A3C;
  localparam logic [DW-1:0] A3 = 18'h0F0F1;
  localparam logic [DW-1:0] B5 = 18'h3FE01;
  localparam logic [DW-1:0] C7 = 18'h000AB;
  localparam logic [DW-1:0] MIX = 18'h3FEAB; // B5 upper lane, C7 lower lane

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // ce slp adv we  be    oe    cke  addr    din    en    dout  req
    '{1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,8'h12,18'h0,1'b0,18'h0,4'd3}, // R3 write load, oe low
    '{1'b0,1'b0,1'b1,1'b1,2'b00,1'b0,1'b0,8'h00,A1,   1'b0,18'h0,4'd4}, // R4 we_n ignored
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,8'h00,A2,   1'b0,18'h0,4'd4},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,1'b0,1'b0,8'h00,A3,   1'b0,18'h0,4'd5}, // R5 abort slot
    '{1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,8'h20,18'h0,1'b0,18'h0,4'd3},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,1'b0,1'b0,8'h00,B5,   1'b0,18'h0,4'd5},
    '{1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,1'b0,8'h20,18'h0,1'b0,18'h0,4'd3}, // lane 0 only
    '{1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,8'h00,C7,   1'b0,18'h0,4'd7}, // R7 deselect
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,8'h00,18'h0,1'b0,18'h0,4'd7}, // R7 deselect-continue
    '{1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,8'h12,18'h0,1'b1,A1,   4'd2}, // R2 read load
    '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,8'h00,18'h0,1'b1,A2,   4'd4}, // R4 ce_n ignored
    '{1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,8'h00,18'h0,1'b1,A3,   4'd4}, // R4 wrap to 0x10
    '{1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b1,8'h55,18'h0,1'b1,A3,   4'd8}, // R8 stall
    '{1'b0,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,8'h00,18'h0,1'b0,18'h0,4'd6}, // R6 dummy, R10 zero
    '{1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,8'h00,18'h0,1'b1,A1,   4'd6}, // R6 counter advanced
    '{1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,8'h20,18'h0,1'b1,MIX,  4'd3}, // R3 lane merge
    '{1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,8'h00,18'h0,1'b0,18'h0,4'd10} // R10
  };

  task automatic drive(input logic c, input logic s, input logic ad, input logic w,
                       input logic [1:0] b, input logic o, input logic k,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = c; sleep = s; adv = ad; we_n = w; be_n = b;
    oe_n = o; cke_n = k; addr = a; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic xen, input logic [DW-1:0] xd);
    checks++;
    if (dout_en !== xen || dout !== xd) begin
      fails++;
      $display("FAIL R%0d: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               req, dout_en, dout, xen, xd);
    end
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1, 1'b0, '0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, '0);
    check(1, 1'b0, '0); // R1 continue after reset drives nothing

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ce_n, VECS[i].slp, VECS[i].adv, VECS[i].we_n, VECS[i].be_n,
            VECS[i].oe_n, VECS[i].cke_n, VECS[i].a, VECS[i].d);
      check(int'(VECS[i].req), VECS[i].xen, VECS[i].xd);
    end

    // R5: an abort leaves old contents intact
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h30, '0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 18'h12345);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 8'h30, '0);
    check(5, 1'b0, '0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 18'h0ABCD);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h30, '0);
    check(5, 1'b1, 18'h12345);

    // R8: write data phase crosses a stall
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h40, '0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 8'h77, 18'h3FFFF);
    check(8, 1'b0, '0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 18'h2468A);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h40, '0);
    check(8, 1'b1, 18'h2468A);

    // R9: sleep ends a read burst, then continue stays deselected
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h30, '0);
    check(9, 1'b1, 18'h12345);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, '0);
    check(9, 1'b0, '0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, '0);
    check(9, 1'b0, '0);

    // R9: sleep drops a pending write
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h30, '0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 18'h00003);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h30, '0);
    check(9, 1'b1, 18'h12345);

    // R1: reset in mid-burst
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, '0);
    rst = 1'b0;
    check(1, 1'b0, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule